// File: doc/BRIEF.md
# Overcurrent Fault Latch Monitor

This block sits between the overcurrent comparators of a push-pull gate driver and its gate controller. It takes one trip flag from the high-side switch and one from the low-side switch. Each flag is a de-glitched logic level that may be asynchronous to the block clock. From these flags the block keeps a latched fault. The fault goes out as an active-low, open-drain indication, so the block drives only a pull-down enable and several devices can share one wired-OR fault line. The block also raises a force-off request for whichever switch tripped, which gives pulse-by-pulse current limiting.

The fault clears itself only after a set number of back-to-back switching cycles with no overcurrent. The default is four. The block counts a switching cycle at each rising edge of the active control input. A low on the enable line or on the power-on reset line clears the fault, the cycle count and both force-off requests at once. While either of those lines is low, new trips are ignored. The control inputs and the mode, enable and reset lines are plain level inputs that are synchronous to the clock. The block has no streaming data interface, so none of its pins carries back-pressure.

Top module: `ocp_fault_monitor`

## Requirements
- R1: After the asynchronous reset `arst_n`, `fault_pd`, `hs_force_off` and `ls_force_off` are all 0.
- R2: A raw trip on either side that is held high sets `fault_pd` to 1 on the third rising clock edge after it is applied. Two of those edges are synchronizer stages. `fault_pd` = 1 means "pull the shared fault line low".
- R3: Once set, the fault holds until four consecutive cycles pass with no synchronized trip on either side. It then drops one clock after the rising edge that ends the fourth clean cycle. A cycle that saw any trip counts as unclean, and it restarts the count.
- R4: With `dual_mode` = 0, only rising edges of `ls_ctl` count as cycles. With `dual_mode` = 1, a rising edge of either `hs_ctl` or `ls_ctl` counts.
- R5: `enable` = 0 forces `fault_pd` to 0 in the same cycle, without waiting for a clock edge. It also clears the latch, the count and both force-off requests, and it ignores trips while low.
- R6: `por_n` = 0 has the same immediate clearing effect as `enable` = 0.
- R7: A held raw trip on one side sets that side's force-off request on the third clock edge. The other side's request is unaffected. At a 5 ns clock this is 15 ns, well inside a 150 ns budget.
- R8: A force-off request releases only at a rising edge of that side's control input, and only if that side's synchronized trip is then low. In dual mode the high side uses `hs_ctl`. In single mode both sides use `ls_ctl`.
- R9: The clean-cycle count saturates at four. After a long clean run, one new trip still needs four fresh clean cycles before the fault clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| arst_n | input | 1 | Asynchronous system reset, active low |
| hs_trip_raw | input | 1 | High-side overcurrent flag, asynchronous |
| ls_trip_raw | input | 1 | Low-side overcurrent flag, asynchronous |
| hs_ctl | input | 1 | High-side control input (dual mode) |
| ls_ctl | input | 1 | Low-side control input; the only control input in single mode |
| dual_mode | input | 1 | 1 = independent control inputs, 0 = single control input |
| enable | input | 1 | Functional enable; low clears the fault |
| por_n | input | 1 | Power-on reset line; low clears the fault |
| fault_pd | output | 1 | Pull-down enable for the shared active-low fault line |
| hs_force_off | output | 1 | Request to hold the high-side gate off |
| ls_force_off | output | 1 | Request to hold the low-side gate off |

## Verification
The hardest case to reach from the ports is the exact clearing boundary. A trip that lingers in the synchronizer across a control edge makes the cycle in which it was seen unclean. Four clean cycles therefore need five rising edges after a trip, and a saturated count from earlier clean running must not shorten that wait. Directed sequences place trips just before control pulses and count pulses one at a time, including pulses on the input that single mode ignores. Long seeded random runs then mix sparse trips, toggling controls, mode changes and short enable or reset drops against a cycle model in the bench.

// File: rtl/ocpm_pkg.sv
package ocpm_pkg;
  localparam int SIDE_HI = 0;
  localparam int SIDE_LO = 1;
  localparam int NSIDES  = 2;

  function automatic int cnt_width(input int max_val);
    return (max_val < 2) ? 1 : $clog2(max_val + 1);
  endfunction
endpackage

// File: rtl/ocpm_sync.sv
module ocpm_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         arst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES:0][W-1:0] chain;

  assign chain[0] = d;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) chain[g+1] <= '0;
        else         chain[g+1] <= chain[g];
      end
    end
  endgenerate

  assign q = chain[STAGES];
endmodule

// File: rtl/ocpm_edge.sv
module ocpm_edge #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         arst_n,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] rise
);
  logic [W-1:0] prev;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) prev <= '0;
    else         prev <= lvl;
  end

  assign rise = lvl & ~prev;
endmodule

// File: rtl/ocpm_side_latch.sv
module ocpm_side_latch (
  input  logic clk,
  input  logic arst_n,
  input  logic clr,
  input  logic trip,
  input  logic rel_edge,
  output logic force_off
);
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)       force_off <= 1'b0;
    else if (clr)      force_off <= 1'b0;
    else if (trip)     force_off <= 1'b1;
    else if (rel_edge) force_off <= 1'b0;
  end

  // R7: a synchronized trip raises this side's request on the next edge
  a_r7_force_on_trip: assert property (@(posedge clk) disable iff (!arst_n)
    (trip && !clr) |=> force_off);

  // R8: the request only drops on a release edge with no trip, or a clear
  a_r8_release_cause: assert property (@(posedge clk) disable iff (!arst_n)
    $fell(force_off) |-> $past(clr || (rel_edge && !trip)));
endmodule

// File: rtl/ocpm_fault_latch.sv
module ocpm_fault_latch
  import ocpm_pkg::*;
#(
  parameter int CLEAN_CYCLES = 4
) (
  input  logic clk,
  input  logic arst_n,
  input  logic clr,
  input  logic any_trip,
  input  logic cyc_evt,
  output logic fault_q
);
  localparam int CNT_W = cnt_width(CLEAN_CYCLES);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(CLEAN_CYCLES);

  logic [CNT_W-1:0] clean_cnt;
  logic             dirty;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      clean_cnt <= '0;
      dirty     <= 1'b0;
    end else if (clr) begin
      clean_cnt <= '0;
      dirty     <= 1'b0;
    end else if (any_trip) begin
      clean_cnt <= '0;
      dirty     <= 1'b1;
    end else if (cyc_evt) begin
      dirty <= 1'b0;
      if (dirty)                     clean_cnt <= '0;
      else if (clean_cnt != CNT_MAX) clean_cnt <= clean_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)                   fault_q <= 1'b0;
    else if (clr)                  fault_q <= 1'b0;
    else if (any_trip)             fault_q <= 1'b1;
    else if (clean_cnt == CNT_MAX) fault_q <= 1'b0;
  end

  // R2: a trip seen while enabled latches the fault
  a_r2_trip_latches: assert property (@(posedge clk) disable iff (!arst_n)
    (any_trip && !clr) |=> fault_q);

  // R3: the fault holds while fewer than the required clean cycles have passed
  a_r3_fault_holds: assert property (@(posedge clk) disable iff (!arst_n)
    (fault_q && !clr && clean_cnt != CNT_MAX) |=> fault_q);

  // R5, R6: a clear always wins over a trip
  a_r5_r6_clear_wins: assert property (@(posedge clk) disable iff (!arst_n)
    clr |=> (!fault_q && clean_cnt == '0));

  // R9: the clean-cycle count never passes its limit
  a_r9_cnt_saturates: assert property (@(posedge clk) disable iff (!arst_n)
    clean_cnt <= CNT_MAX);
endmodule

// File: rtl/ocp_fault_monitor.sv
module ocp_fault_monitor
  import ocpm_pkg::*;
#(
  parameter int CLEAN_CYCLES = 4,
  parameter int SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic arst_n,
  input  logic hs_trip_raw,
  input  logic ls_trip_raw,
  input  logic hs_ctl,
  input  logic ls_ctl,
  input  logic dual_mode,
  input  logic enable,
  input  logic por_n,
  output logic fault_pd,
  output logic hs_force_off,
  output logic ls_force_off
);
  logic [NSIDES-1:0] trip_s;
  logic [NSIDES-1:0] ctl_rise;
  logic [NSIDES-1:0] rel_edge;
  logic [NSIDES-1:0] force_q;
  logic              clr;
  logic              cyc_evt;
  logic              fault_q;

  ocpm_sync #(.W(NSIDES), .STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .arst_n(arst_n),
    .d({ls_trip_raw, hs_trip_raw}), .q(trip_s)
  );

  ocpm_edge #(.W(NSIDES)) i_edge (
    .clk(clk), .arst_n(arst_n),
    .lvl({ls_ctl, hs_ctl}), .rise(ctl_rise)
  );

  assign clr     = !enable || !por_n;
  assign cyc_evt = dual_mode ? (|ctl_rise) : ctl_rise[SIDE_LO];

  assign rel_edge[SIDE_HI] = dual_mode ? ctl_rise[SIDE_HI] : ctl_rise[SIDE_LO];
  assign rel_edge[SIDE_LO] = ctl_rise[SIDE_LO];

  genvar s;
  generate
    for (s = 0; s < NSIDES; s++) begin : g_side
      ocpm_side_latch i_side (
        .clk(clk), .arst_n(arst_n), .clr(clr),
        .trip(trip_s[s]), .rel_edge(rel_edge[s]), .force_off(force_q[s])
      );
    end
  endgenerate

  ocpm_fault_latch #(.CLEAN_CYCLES(CLEAN_CYCLES)) i_fault (
    .clk(clk), .arst_n(arst_n), .clr(clr),
    .any_trip(|trip_s), .cyc_evt(cyc_evt), .fault_q(fault_q)
  );

  assign fault_pd     = fault_q && enable && por_n;
  assign hs_force_off = force_q[SIDE_HI];
  assign ls_force_off = force_q[SIDE_LO];

  // R4: in single mode the high-side control input never ends a cycle
  a_r4_single_mode_edge: assert property (@(posedge clk) disable iff (!arst_n)
    (!dual_mode && !ctl_rise[SIDE_LO]) |-> !cyc_evt);
endmodule

// File: tb/test_ocp_fault_monitor.sv
`timescale 1ns/100ps
module test_ocp_fault_monitor;
  logic clk = 1'b0;
  logic arst_n = 1'b0;
  logic hs_trip_raw = 1'b0, ls_trip_raw = 1'b0;
  logic hs_ctl = 1'b0, ls_ctl = 1'b0;
  logic dual_mode = 1'b1, enable = 1'b1, por_n = 1'b1;
  logic fault_pd, hs_force_off, ls_force_off;

  int n_checks = 0;
  int n_fails  = 0;
  bit auto_on  = 1'b0;

  always #2.5 clk = ~clk;

  ocp_fault_monitor i_ocp_fault_monitor (
    .clk(clk), .arst_n(arst_n),
    .hs_trip_raw(hs_trip_raw), .ls_trip_raw(ls_trip_raw),
    .hs_ctl(hs_ctl), .ls_ctl(ls_ctl), .dual_mode(dual_mode),
    .enable(enable), .por_n(por_n),
    .fault_pd(fault_pd), .hs_force_off(hs_force_off), .ls_force_off(ls_force_off)
  );

  // Reference model built from the requirements
  logic [1:0] m_s1, m_s2, m_prev, m_force;
  int  m_cnt;
  bit  m_dirty, m_fault;

  wire [1:0] m_rise = {ls_ctl, hs_ctl} & ~m_prev;
  wire m_clr = !enable || !por_n;
  wire m_any = |m_s2;
  wire m_evt = dual_mode ? (|m_rise) : m_rise[1];
  wire [1:0] m_rel = {m_rise[1], dual_mode ? m_rise[0] : m_rise[1]};

  function automatic int f_cnt(int c, bit dirty, bit trip, bit evt, bit clr);
    if (clr || trip) return 0;
    if (evt) return dirty ? 0 : ((c >= 4) ? 4 : c + 1);
    return c;
  endfunction

  function automatic bit f_dirty(bit d, bit trip, bit evt, bit clr);
    if (clr) return 1'b0;
    if (trip) return 1'b1;
    if (evt) return 1'b0;
    return d;
  endfunction

  function automatic bit f_fault(bit f, int c, bit trip, bit clr);
    if (clr) return 1'b0;
    if (trip) return 1'b1;
    if (c == 4) return 1'b0;
    return f;
  endfunction

  function automatic bit f_force(bit f, bit trip, bit rel, bit clr);
    if (clr) return 1'b0;
    if (trip) return 1'b1;
    if (rel) return 1'b0;
    return f;
  endfunction

  always @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      m_s1 <= '0; m_s2 <= '0; m_prev <= '0; m_force <= '0;
      m_cnt <= 0; m_dirty <= 1'b0; m_fault <= 1'b0;
    end else begin
      m_s1    <= {ls_trip_raw, hs_trip_raw};
      m_s2    <= m_s1;
      m_prev  <= {ls_ctl, hs_ctl};
      m_cnt   <= f_cnt(m_cnt, m_dirty, m_any, m_evt, m_clr);
      m_dirty <= f_dirty(m_dirty, m_any, m_evt, m_clr);
      m_fault <= f_fault(m_fault, m_cnt, m_any, m_clr);
      for (int i = 0; i < 2; i++)
        m_force[i] <= f_force(m_force[i], m_s2[i], m_rel[i], m_clr);
    end
  end

  task automatic check(input string tag, input string what, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (auto_on) begin
      check("R3", "fault_pd vs model", fault_pd, m_fault && enable && por_n);
      check("R8", "hs_force_off vs model", hs_force_off, m_force[0]);
      check("R8", "ls_force_off vs model", ls_force_off, m_force[1]);
    end
  end

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic pulse_hs();
    hs_ctl = 1'b1; tick(); hs_ctl = 1'b0; tick();
  endtask

  task automatic pulse_ls();
    ls_ctl = 1'b1; tick(); ls_ctl = 1'b0; tick();
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4242));
    tick(3);
    check("R1", "fault_pd in reset", fault_pd, 1'b0);
    arst_n = 1'b1;
    tick();
    check("R1", "fault_pd after reset", fault_pd, 1'b0);
    check("R1", "hs_force_off after reset", hs_force_off, 1'b0);
    check("R1", "ls_force_off after reset", ls_force_off, 1'b0);
    auto_on = 1'b1;

    // R2 / R7: high-side trip, dual mode
    dual_mode = 1'b1;
    hs_trip_raw = 1'b1;
    tick(2);
    check("R2", "fault not before third edge", fault_pd, 1'b0);
    tick();
    check("R2", "fault on third edge", fault_pd, 1'b1);
    check("R7", "hs forced off", hs_force_off, 1'b1);
    check("R7", "ls untouched", ls_force_off, 1'b0);
    hs_trip_raw = 1'b0;
    tick(3);
    // R3: the unclean cycle plus four clean ones
    for (int i = 0; i < 4; i++) pulse_ls();
    check("R3", "fault held after four edges", fault_pd, 1'b1);
    check("R8", "hs not released by ls edge", hs_force_off, 1'b1);
    pulse_ls();
    check("R3", "fault cleared after fourth clean cycle", fault_pd, 1'b0);
    pulse_hs();
    check("R8", "hs released by hs edge", hs_force_off, 1'b0);

    // R4: single mode, hs_ctl does not count
    dual_mode = 1'b0;
    ls_trip_raw = 1'b1;
    tick(3);
    check("R7", "ls forced off", ls_force_off, 1'b1);
    check("R7", "hs untouched by ls trip", hs_force_off, 1'b0);
    ls_trip_raw = 1'b0;
    tick(3);
    for (int i = 0; i < 6; i++) pulse_hs();
    check("R4", "hs_ctl ignored in single mode", fault_pd, 1'b1);
    check("R8", "ls not released by hs edge", ls_force_off, 1'b1);
    pulse_ls();
    check("R8", "ls released by ls edge", ls_force_off, 1'b0);
    for (int i = 0; i < 3; i++) pulse_ls();
    check("R4", "three clean cycles not enough", fault_pd, 1'b1);
    pulse_ls();
    check("R4", "ls_ctl cycles clear fault", fault_pd, 1'b0);

    // R5: enable low
    dual_mode = 1'b1;
    hs_trip_raw = 1'b1;
    tick(3);
    check("R5", "fault set before disable", fault_pd, 1'b1);
    enable = 1'b0;
    #1;
    check("R5", "fault drops with no clock edge", fault_pd, 1'b0);
    tick(4);
    check("R5", "trip ignored while disabled", hs_force_off, 1'b0);
    hs_trip_raw = 1'b0;
    tick(3);
    enable = 1'b1;
    tick();
    check("R5", "fault stays clear after enable", fault_pd, 1'b0);

    // R6: por_n low
    ls_trip_raw = 1'b1;
    tick(3);
    check("R6", "fault set before por", fault_pd, 1'b1);
    por_n = 1'b0;
    #1;
    check("R6", "fault drops with no clock edge", fault_pd, 1'b0);
    tick(4);
    check("R6", "ls request cleared", ls_force_off, 1'b0);
    ls_trip_raw = 1'b0;
    tick(3);
    por_n = 1'b1;
    tick();
    check("R6", "fault stays clear after por", fault_pd, 1'b0);

    // R9: saturated count does not shorten the wait
    for (int i = 0; i < 10; i++) pulse_ls();
    hs_trip_raw = 1'b1;
    tick();
    hs_trip_raw = 1'b0;
    tick(2);
    check("R9", "brief trip latches fault", fault_pd, 1'b1);
    tick(2);
    for (int i = 0; i < 4; i++) pulse_hs();
    check("R9", "count restarted after trip", fault_pd, 1'b1);
    pulse_hs();
    check("R9", "cleared after fresh clean cycles", fault_pd, 1'b0);

    // Seeded random run against the model
    for (int i = 0; i < 6000; i++) begin
      tick();
      hs_trip_raw = ($urandom_range(59) == 0);
      ls_trip_raw = ($urandom_range(59) == 0);
      if ($urandom_range(2) == 0) hs_ctl = ~hs_ctl;
      if ($urandom_range(2) == 0) ls_ctl = ~ls_ctl;
      if ($urandom_range(499) == 0) dual_mode = ~dual_mode;
      enable = ($urandom_range(199) != 0);
      por_n  = ($urandom_range(299) != 0);
    end
    hs_trip_raw = 1'b0;
    ls_trip_raw = 1'b0;
    enable = 1'b1;
    por_n = 1'b1;
    tick(4);
    auto_on = 1'b0;
    finish_run();
  end
endmodule